// File: doc/BRIEF.md
# Half-Band Rate and Sync Controller

This block is the rate controller for a 2:1 half-band interpolating and decimating filter. Two active-low rate pins select one of four sample-rate modes. From the selected mode the block derives three things on each clock: the input-register enable, the select that puts an inserted zero in place of a sample, and the strobe for the output register. It also signals the output stage when the -6 dB interpolation gain applies, so that stage can pick its saturation limits.

The half-rate phase is one toggle bit. It runs freely, and a falling edge on the sync input pulls it into the capture phase. A falling edge means sync was high on the previous clock and is low on this one. The first valid input word is present on that same clock. Sync can therefore be held low between realignments, or toggled at half the clock rate, and either use leaves the phase unchanged. In equal-rate mode sync is ignored. The 12-bit two's-complement input word is registered on the rising clock edge and handed to the filter core. For testing, the core is modelled as a pass-through, so the block's data output is the core input stage.

Top module: `rate_sync_ctrl`

## Requirements
- R1: `half_gain` is 1 exactly when `up_n`=0 and `down_n`=1 (-6 dB interpolation); it is 0 in the other three modes, and it follows the pins combinationally.
- R2: Equal-rate mode (`up_n`=1, `down_n`=1): `in_en` is 1 on every clock, and after every edge `core_data` equals the `din` sampled at that edge, with `zero_sel`=0 and `out_stb`=1.
- R3: -6 dB interpolation (`up_n`=0, `down_n`=1): `in_en` alternates 1,0,1,0 between alignments. After a capture edge `core_data` holds the captured `din` and `zero_sel`=0. After a non-capture edge `core_data`=0 and `zero_sel`=1. `out_stb`=1 after every edge.
- R4: Decimation (`up_n`=1, `down_n`=0): `in_en` is 1 on every clock, and `core_data` follows `din` as in R2. `zero_sel` stays 0, and `out_stb` is 1 only after capture-phase edges, which gives every other clock between alignments.
- R5: Unity-gain interpolation (`up_n`=0, `down_n`=0) has the same capture, zero-insert and strobe sequence as R3.
- R6: Outside equal-rate mode, a clock with `sync_in`=0 whose previous clock had `sync_in`=1 is a capture-phase clock. The next clock is then a non-capture clock.
- R7: In equal-rate mode `sync_in` has no effect. Outside it, toggling `sync_in` at half the clock rate in step with capture gives the same phase as holding it low.
- R8: After a clock edge with `rst_n`=0: `core_data`=0, `zero_sel`=0 and `out_stb`=0. The first clock after reset is released is a capture-phase clock. The remembered sync level restarts at 0.
- R9: The full 12-bit two's-complement range (-2048 to 2047) passes from `din` to `core_data` unchanged on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| up_n | input | 1 | Rate pin; low requests interpolation |
| down_n | input | 1 | Rate pin; low requests decimation |
| sync_in | input | 1 | Phase alignment; high-to-low marks the first input word |
| din | input | 12 | Two's-complement input word |
| in_en | output | 1 | Input register enable for the current clock |
| core_data | output | 12 | Sample or inserted zero passed to the filter core |
| zero_sel | output | 1 | The current core sample is an inserted zero |
| out_stb | output | 1 | The output register takes a result on this cycle |
| half_gain | output | 1 | -6 dB interpolation gain is in effect |

## Verification
The properties assume the rate pins are driven to settled levels before each rising edge. They also assume that a mode change is a deliberate realignment point, so alternation is only required across clocks that share a mode and lie after reset release. The stimulus changes its inputs only on falling clock edges. It holds each mode for a whole run of clocks, or switches it between runs, and it drives sync in three patterns: held low, toggled in step with capture, and single falls on an odd cycle that force a phase jump.

// File: rtl/rsc_pkg.sv
// Package: shared rate-mode type and decode helper for the rate controller.
// Assumes the two rate pins are active low and settled before each clock.
package rsc_pkg;

    typedef enum logic [1:0] {
        RM_EQUAL        = 2'd0,
        RM_INTERP_HALF  = 2'd1,
        RM_DECIM        = 2'd2,
        RM_INTERP_UNITY = 2'd3
    } rate_mode_t;

    // Map the two active-low rate pins onto a mode.
    function automatic rate_mode_t decode_rate(input logic up_n, input logic down_n);
        rate_mode_t m;
        case ({up_n, down_n})
            2'b11:   m = RM_EQUAL;
            2'b01:   m = RM_INTERP_HALF;
            2'b10:   m = RM_DECIM;
            default: m = RM_INTERP_UNITY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rsc_mode_dec.sv
// Module: rsc_mode_dec
// Decodes the rate pins into a mode and the per-mode qualifiers used by the
// phase tracker and the sample path. Purely combinational. It assumes the pins
// are quasi-static relative to the clock.
module rsc_mode_dec
    import rsc_pkg::*;
(
    input  logic       up_n,
    input  logic       down_n,
    output rate_mode_t mode,
    output logic       is_equal,
    output logic       is_interp,
    output logic       is_decim,
    output logic       half_gain
);

    // Decode the mode and derive the one-hot style qualifiers.
    always_comb begin
        mode      = decode_rate(up_n, down_n);
        is_equal  = (mode == RM_EQUAL);
        is_decim  = (mode == RM_DECIM);
        is_interp = (mode == RM_INTERP_HALF) || (mode == RM_INTERP_UNITY);
        half_gain = (mode == RM_INTERP_HALF);
    end

endmodule

// File: rtl/rsc_phase_trk.sv
// Module: rsc_phase_trk
// Tracks the half-rate phase. A one-bit toggle marks capture clocks. A
// high-to-low transition on sync forces the current clock into the capture
// phase. Otherwise the toggle free-runs. Sync is masked in equal-rate mode.
// It assumes sync is synchronous to clk.
module rsc_phase_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic is_equal,
    output logic cap,
    output logic sync_fall
);

    logic sync_q;
    logic ph_q;

    // Detect a qualified falling edge and resolve the current capture phase.
    always_comb begin
        sync_fall = sync_q && !sync_in && !is_equal;
        cap       = sync_fall || ph_q;
    end

    // Remember the previous sync level and advance the phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            ph_q   <= 1'b1;
        end else begin
            sync_q <= sync_in;
            ph_q   <= !cap;
        end
    end

endmodule

// File: rtl/rsc_sample_path.sv
// Module: rsc_sample_path
// Registers the input word, or an inserted zero, for the filter core. Also
// generates the input enable and the output-register strobe. It assumes the
// cap and mode qualifiers are valid for the current clock.
module rsc_sample_path #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          is_interp,
    input  logic          is_decim,
    input  logic          cap,
    output logic          in_en,
    output logic [DW-1:0] core_data,
    output logic          zero_sel,
    output logic          out_stb
);

    localparam logic [DW-1:0] ZERO_WORD = '0;

    logic stuff_now;

    // Interpolation captures only on capture clocks; other modes on every clock.
    always_comb begin
        in_en     = is_interp ? cap : 1'b1;
        stuff_now = is_interp && !cap;
    end

    // Load the sample or an inserted zero and the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_data <= ZERO_WORD;
            zero_sel  <= 1'b0;
            out_stb   <= 1'b0;
        end else begin
            core_data <= stuff_now ? ZERO_WORD : din;
            zero_sel  <= stuff_now;
            out_stb   <= is_decim ? cap : 1'b1;
        end
    end

endmodule

// File: rtl/rate_sync_ctrl.sv
// Module: rate_sync_ctrl
// Top level of the half-band rate and sync controller. It ties the mode
// decoder, the phase tracker and the sample path together. It assumes a
// single clock and a synchronous active-low reset.
module rate_sync_ctrl #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_n,
    input  logic          down_n,
    input  logic          sync_in,
    input  logic [DW-1:0] din,
    output logic          in_en,
    output logic [DW-1:0] core_data,
    output logic          zero_sel,
    output logic          out_stb,
    output logic          half_gain
);

    import rsc_pkg::*;

    rate_mode_t mode;
    logic       is_equal;
    logic       is_interp;
    logic       is_decim;
    logic       cap;
    logic       sync_fall;

    rsc_mode_dec u_dec (
        .up_n      (up_n),
        .down_n    (down_n),
        .mode      (mode),
        .is_equal  (is_equal),
        .is_interp (is_interp),
        .is_decim  (is_decim),
        .half_gain (half_gain)
    );

    rsc_phase_trk u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .is_equal  (is_equal),
        .cap       (cap),
        .sync_fall (sync_fall)
    );

    rsc_sample_path #(.DW(DW)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .is_interp (is_interp),
        .is_decim  (is_decim),
        .cap       (cap),
        .in_en     (in_en),
        .core_data (core_data),
        .zero_sel  (zero_sel),
        .out_stb   (out_stb)
    );

endmodule

// File: rtl/rate_sync_ctrl_chk.sv
// Module: rate_sync_ctrl_chk
// Property checker bound into rate_sync_ctrl. It observes the ports and the
// capture-phase line between the phase tracker and the sample path.
module rate_sync_ctrl_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          up_n,
    input logic          down_n,
    input logic          sync_in,
    input logic          in_en,
    input logic [DW-1:0] core_data,
    input logic          zero_sel,
    input logic          out_stb,
    input logic          half_gain,
    input logic          cap
);

    logic pin_equal;
    logic pin_interp;
    logic pin_decim;

    // Independent pin-level mode view for the properties.
    always_comb begin
        pin_equal  = up_n && down_n;
        pin_interp = !up_n;
        pin_decim  = up_n && !down_n;
    end

    AST_GAIN_ONLY_HALF_INTERP: assert property (@(posedge clk) disable iff (!rst_n)
        half_gain |-> (!up_n && down_n)); // R1

    AST_EQUAL_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        pin_equal |-> in_en); // R2

    AST_EQUAL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        pin_equal |=> out_stb); // R2

    AST_STUFFED_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_sel |-> (core_data == '0)); // R3

    AST_INTERP_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pin_interp && $past(pin_interp) && !($past(sync_in) && !sync_in))
        |-> (in_en != $past(in_en))); // R5

    AST_DECIM_NO_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
        pin_decim |=> !zero_sel); // R4

    AST_SYNC_FALL_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pin_equal && $past(sync_in) && !sync_in) |-> cap); // R6

    AST_FIRST_CLOCK_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cap && !zero_sel && !out_stb)); // R8

endmodule

bind rate_sync_ctrl rate_sync_ctrl_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_n      (up_n),
    .down_n    (down_n),
    .sync_in   (sync_in),
    .in_en     (in_en),
    .core_data (core_data),
    .zero_sel  (zero_sel),
    .out_stb   (out_stb),
    .half_gain (half_gain),
    .cap       (cap)
);

// File: tb/tb_rate_sync_ctrl.sv
module tb_rate_sync_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_n = 1'b1;
    logic          down_n = 1'b1;
    logic          sync_in = 1'b0;
    logic [DW-1:0] din = '0;
    logic          in_en;
    logic [DW-1:0] core_data;
    logic          zero_sel;
    logic          out_stb;
    logic          half_gain;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state held by the bench
    bit m_ph    = 1'b1;
    bit m_syncp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_sync_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .up_n(up_n), .down_n(down_n),
        .sync_in(sync_in), .din(din), .in_en(in_en), .core_data(core_data),
        .zero_sel(zero_sel), .out_stb(out_stb), .half_gain(half_gain)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input bit u, input bit d);
        if (u && d)  return "R2";
        if (!u && d) return "R3";
        if (u && !d) return "R4";
        return "R5";
    endfunction

    // One clock: inputs set after a falling edge, results checked at the next falling edge.
    task automatic cycle(input bit u, input bit d, input bit s, input logic [DW-1:0] w, input string stag);
        bit eq, ip, dc, fall, cap, e_en, e_zs, e_stb;
        logic [DW-1:0] e_dat;
        string t;
        up_n = u; down_n = d; sync_in = s; din = w;
        eq = u && d; ip = !u; dc = u && !d;
        fall = m_syncp && !s && !eq;
        cap  = fall || m_ph;
        e_en = ip ? cap : 1'b1;
        e_zs = ip && !cap;
        e_dat = e_zs ? '0 : w;
        e_stb = dc ? cap : 1'b1;
        t = mode_tag(u, d);
        #1;
        check(half_gain == (!u && d), "R1 half_gain", half_gain, int'(!u && d));
        check(in_en == e_en, fall ? "R6 in_en" : {t, " in_en"}, in_en, e_en);
        @(posedge clk);
        m_syncp = s;
        m_ph = !cap;
        @(negedge clk);
        check(core_data == e_dat, {t, " ", stag, " R9 core_data"}, int'(core_data), int'(e_dat));
        check(zero_sel == e_zs, {t, " zero_sel"}, zero_sel, e_zs);
        check(out_stb == e_stb, {t, " ", stag, " out_stb"}, out_stb, e_stb);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(core_data == '0, "R8 core_data", int'(core_data), 0);
        check(zero_sel == 1'b0, "R8 zero_sel", zero_sel, 0);
        check(out_stb == 1'b0, "R8 out_stb", out_stb, 0);
        rst_n = 1'b1;
        m_ph = 1'b1;
        m_syncp = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Sweep every mode against three sync patterns and a data ramp.
        for (int md = 0; md < 4; md++) begin
            for (int sp = 0; sp < 3; sp++) begin
                bit u, d;
                u = md[1]; d = md[0];
                do_reset();
                for (int k = 0; k < 40; k++) begin
                    bit s;
                    logic [DW-1:0] w;
                    w = DW'(k * 397 - 2048);
                    if (k == 0) w = 12'h800;      // -2048
                    if (k == 1) w = 12'h7FF;      // 2047
                    if (sp == 0) s = 1'b0;                        // held low
                    else if (sp == 1) s = (k % 2 == 1);            // toggled in step, R7
                    else s = (k == 6) || (k == 13) || (k == 26);   // isolated pulses
                    cycle(u, d, s, w, sp == 1 ? "R7" : "SY");
                end
            end
        end
        // Held-low versus toggled sync give the same phase in interpolation (R7).
        do_reset();
        for (int k = 0; k < 16; k++) cycle(1'b0, 1'b1, k[0], DW'(k + 1), "R7");
        // Equal-rate ignores sync (R2, R7), then switch modes on the fly.
        for (int k = 0; k < 16; k++) cycle(1'b1, 1'b1, k[0] ^ k[2], DW'(100 + k), "R7");
        for (int k = 0; k < 24; k++) begin
            bit u, d;
            u = (k / 6) % 2 == 1;
            d = (k / 3) % 2 == 1;
            cycle(u, d, (k == 9) || (k == 17), DW'(k * 171), "SY");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule